// File: doc/BRIEF.md
# Glitch-Free Clock Output Gating Bank

This block sits between a set of free-running clock sources and the clock output pins of a system clock chip. Each output, or group of outputs, has an enable bit: 1 lets the clock run, 0 stops it. A stopped output is held at logic low. Every enable is synchronised into the clock domain it controls. The gate opens or closes only while that clock is low, so no high pulse is ever cut short and a restart never produces a partial pulse.

Two global controls act on top of the enable bits. An active-low power-down input stops every output, the SDRAM fanout included. An active-low CPU-stop input halts the CPU pair and the chipset clock, but only when the latched mode input is 0. In mode 1 the shared pin is a reference clock output, and the stop input is ignored. A select bit chooses whether the shared peripheral pin carries the 24 MHz or the 48 MHz source. A handoff keeps that pin low across the switch. The bank has no data stream, so every pin is a plain clock or control level and there is no back-pressure.

Top module: `clkgate_bank`

## Requirements
- R1: While reset is released, power-down is high and an output's enable bit is 1, that output toggles at its source rate. With the bit at 0 the output is held at logic low. Each PCI output has its own bit (`en_pci[i]` gates `pci_clk[i]`), and so do the 48 MHz output (`en_usb`) and each reference output (`en_ref[i]`).
- R2: The first twelve SDRAM outputs are enabled in groups of four: `en_sdr_grp[0]` gates `sdr_clk[3:0]`, `en_sdr_grp[1]` gates `sdr_clk[7:4]` and `en_sdr_grp[2]` gates `sdr_clk[11:8]`. `sdr_clk[12]` is gated only by `en_sdr_last`.
- R3: Every high pulse on every output has the full high width of its source. A gate changes state only while its source clock is low.
- R4: While `pd_n` is 0, every output is held low whatever the enable bits say. When `pd_n` returns to 1, enabled outputs run again.
- R5: With `mode` = 0 and `cpu_stop_n` = 0, the CPU true, CPU complement and chipset outputs halt at logic low, and the PCI outputs keep running. With `mode` = 1, `cpu_stop_n` has no effect.
- R6: The single bit `en_cpu` gates `cpu_t`, `cpu_c` and `cpu_cs` together. While running, `cpu_cs` equals `cpu_t` and `cpu_c` is the inverse of `cpu_t`.
- R7: `mux_clk` carries `clk_24` when `sel_mux_hi` = 0 and `clk_48` when `sel_mux_hi` = 1. It is gated by `en_mux`.
- R8: When `sel_mux_hi` changes, `mux_clk` stays low for at least one full period of the slower source (16 ns with the default sources) before the new source appears.
- R9: `ref_clk[0]` is held low while `mode` = 0, because its pin then serves as the CPU-stop input. In mode 1 it follows `en_ref[0]`.
- R10: While `rst_n` is 0, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all gate state |
| mode | input | 1 | Latched mode: 0 makes the shared pin a CPU-stop input, 1 makes it a reference output |
| pd_n | input | 1 | Active-low power-down; stops every output |
| cpu_stop_n | input | 1 | Active-low CPU-stop, honoured only in mode 0 |
| clk_cpu | input | 1 | CPU clock source |
| clk_pci | input | 1 | PCI clock source |
| clk_sdr | input | 1 | SDRAM fanout buffer input |
| clk_24 | input | 1 | 24 MHz source |
| clk_48 | input | 1 | 48 MHz source |
| clk_ref | input | 1 | Reference clock source |
| en_cpu | input | 1 | Enable for the CPU pair and the chipset clock |
| en_pci | input | NUM_PCI | Per-output PCI enables |
| en_sdr_grp | input | SDR_GROUPS | SDRAM group enables |
| en_sdr_last | input | 1 | Enable for the ungrouped SDRAM output |
| en_usb | input | 1 | Enable for the 48 MHz output |
| en_mux | input | 1 | Enable for the 24/48 selectable output |
| sel_mux_hi | input | 1 | 0 selects 24 MHz, 1 selects 48 MHz on the selectable output |
| en_ref | input | NUM_REF | Reference output enables |
| cpu_t | output | 1 | Gated CPU true clock |
| cpu_c | output | 1 | Gated CPU complement clock |
| cpu_cs | output | 1 | Gated chipset clock, in phase with cpu_t |
| pci_clk | output | NUM_PCI | Gated PCI clocks |
| sdr_clk | output | SDR_GROUPS*SDR_PER_GROUP+1 | Gated SDRAM clocks |
| usb_clk | output | 1 | Gated 48 MHz clock |
| mux_clk | output | 1 | Gated 24 or 48 MHz clock |
| ref_clk | output | NUM_REF | Gated reference clocks |

## Verification
The bench goes after the group decode of the SDRAM enables. A design that mapped a bit to the wrong four outputs, or folded the thirteenth output into a group, would run clocks that should be stopped.

It checks that the CPU-stop input halts only the CPU pair and the chipset clock, and only in mode 0. It checks that the reference output on the shared pin goes quiet in that mode. It checks that power-down overrides enables that are all set.

Every output is watched continuously for a high pulse shorter than its source's high phase. An ungated AND with an unsynchronised enable would leave such a runt. The 24/48 switch is measured for its low gap: a plain multiplexer would show a normal half-period gap, or a merged pulse, instead of the required dead time.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
  localparam int unsigned PCI_COUNT       = 6;
  localparam int unsigned SDR_GROUP_COUNT = 3;
  localparam int unsigned SDR_GROUP_SIZE  = 4;
  localparam int unsigned REF_COUNT       = 2;
  localparam int unsigned GATE_SYNC       = 2;
  localparam int unsigned MUX_SYNC        = 3;
  localparam int unsigned BR_LO           = 0;
  localparam int unsigned BR_HI           = 1;
endpackage

// File: rtl/clkgate_cell.sv
`timescale 1ns/1ps
module clkgate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en_async,
  output logic clk_out
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   open_q;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
  end

  // falling-edge update: gate changes only during the low phase
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= sync_q[SYNC_STAGES-1];
  end

  assign clk_out = clk_src & open_q;
endmodule

// File: rtl/clkmux_cell.sv
`timescale 1ns/1ps
module clkmux_cell #(
  parameter int unsigned SYNC_STAGES = 3
) (
  input  logic clk_lo,
  input  logic clk_hi,
  input  logic rst_n,
  input  logic run,
  input  logic sel_hi,
  output logic clk_out
);
  import clkgate_pkg::*;

  logic [1:0] src_clk;
  logic [1:0] want;
  logic [1:0] open_q;
  logic [1:0] gated;

  assign src_clk = {clk_hi, clk_lo};
  // each branch may open only once the other has closed
  assign want[BR_LO] = run & ~sel_hi & ~open_q[BR_HI];
  assign want[BR_HI] = run &  sel_hi & ~open_q[BR_LO];

  for (genvar b = 0; b < 2; b++) begin : g_branch
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge src_clk[b] or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], want[b]};
    end

    always_ff @(negedge src_clk[b] or negedge rst_n) begin
      if (!rst_n) open_q[b] <= 1'b0;
      else        open_q[b] <= sync_q[SYNC_STAGES-1];
    end

    assign gated[b] = src_clk[b] & open_q[b];
  end

  assign clk_out = |gated;
endmodule

// File: rtl/clkgate_bank.sv
`timescale 1ns/1ps
module clkgate_bank #(
  parameter int unsigned NUM_PCI         = clkgate_pkg::PCI_COUNT,
  parameter int unsigned SDR_GROUPS      = clkgate_pkg::SDR_GROUP_COUNT,
  parameter int unsigned SDR_PER_GROUP   = clkgate_pkg::SDR_GROUP_SIZE,
  parameter int unsigned NUM_REF         = clkgate_pkg::REF_COUNT,
  parameter int unsigned SYNC_STAGES     = clkgate_pkg::GATE_SYNC,
  parameter int unsigned MUX_SYNC_STAGES = clkgate_pkg::MUX_SYNC
) (
  input  logic                                   rst_n,
  input  logic                                   mode,
  input  logic                                   pd_n,
  input  logic                                   cpu_stop_n,
  input  logic                                   clk_cpu,
  input  logic                                   clk_pci,
  input  logic                                   clk_sdr,
  input  logic                                   clk_24,
  input  logic                                   clk_48,
  input  logic                                   clk_ref,
  input  logic                                   en_cpu,
  input  logic [NUM_PCI-1:0]                     en_pci,
  input  logic [SDR_GROUPS-1:0]                  en_sdr_grp,
  input  logic                                   en_sdr_last,
  input  logic                                   en_usb,
  input  logic                                   en_mux,
  input  logic                                   sel_mux_hi,
  input  logic [NUM_REF-1:0]                     en_ref,
  output logic                                   cpu_t,
  output logic                                   cpu_c,
  output logic                                   cpu_cs,
  output logic [NUM_PCI-1:0]                     pci_clk,
  output logic [SDR_GROUPS*SDR_PER_GROUP:0]      sdr_clk,
  output logic                                   usb_clk,
  output logic                                   mux_clk,
  output logic [NUM_REF-1:0]                     ref_clk
);
  localparam int unsigned SDR_GROUPED = SDR_GROUPS * SDR_PER_GROUP;

  logic cpu_run;
  logic clk_cpu_n;

  // stop input only exists in mode 0; power-down overrides everything
  assign cpu_run   = en_cpu & pd_n & (mode | cpu_stop_n);
  assign clk_cpu_n = ~clk_cpu;

  clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_t (
    .clk_src(clk_cpu), .rst_n(rst_n), .en_async(cpu_run), .clk_out(cpu_t));
  clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_cs (
    .clk_src(clk_cpu), .rst_n(rst_n), .en_async(cpu_run), .clk_out(cpu_cs));
  // complement has its own gate so its high phase is protected too
  clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_c (
    .clk_src(clk_cpu_n), .rst_n(rst_n), .en_async(cpu_run), .clk_out(cpu_c));

  for (genvar p = 0; p < NUM_PCI; p++) begin : g_pci
    clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src(clk_pci), .rst_n(rst_n), .en_async(en_pci[p] & pd_n),
      .clk_out(pci_clk[p]));
  end

  for (genvar s = 0; s < SDR_GROUPED; s++) begin : g_sdr
    clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src(clk_sdr), .rst_n(rst_n),
      .en_async(en_sdr_grp[s / SDR_PER_GROUP] & pd_n),
      .clk_out(sdr_clk[s]));
  end

  clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_sdr_last (
    .clk_src(clk_sdr), .rst_n(rst_n), .en_async(en_sdr_last & pd_n),
    .clk_out(sdr_clk[SDR_GROUPED]));

  clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_usb (
    .clk_src(clk_48), .rst_n(rst_n), .en_async(en_usb & pd_n), .clk_out(usb_clk));

  clkmux_cell #(.SYNC_STAGES(MUX_SYNC_STAGES)) u_mux (
    .clk_lo(clk_24), .clk_hi(clk_48), .rst_n(rst_n), .run(en_mux & pd_n),
    .sel_hi(sel_mux_hi), .clk_out(mux_clk));

  for (genvar r = 0; r < NUM_REF; r++) begin : g_ref
    logic ref_run;
    if (r == 0) begin : g_shared
      assign ref_run = en_ref[r] & pd_n & mode;
    end else begin : g_plain
      assign ref_run = en_ref[r] & pd_n;
    end
    clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src(clk_ref), .rst_n(rst_n), .en_async(ref_run), .clk_out(ref_clk[r]));
  end
endmodule

// File: rtl/clkgate_bank_chk.sv
`timescale 1ns/1ps
module clkgate_bank_chk (
  input logic rst_n,
  input logic mode,
  input logic pd_n,
  input logic cpu_stop_n,
  input logic en_cpu,
  input logic clk_cpu,
  input logic clk_pci,
  input logic clk_sdr,
  input logic clk_ref,
  input logic cpu_t,
  input logic cpu_c,
  input logic cpu_cs,
  input logic pci_clk0,
  input logic sdr_clk0,
  input logic ref_clk0
);
  logic [2:0] since_rst;
  logic       cpu_want;

  always_ff @(negedge clk_cpu or negedge rst_n) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 3'd7)  since_rst <= since_rst + 3'd1;
  end

  assign cpu_want = en_cpu && pd_n && (mode || cpu_stop_n);

  // R3: edges of gated outputs line up with source edges
  always @(negedge cpu_t)
    if (rst_n === 1'b1) a_r3_cpu_t_fall: assert (clk_cpu === 1'b0);
  always @(posedge cpu_t)
    if (rst_n === 1'b1) a_r3_cpu_t_rise: assert (clk_cpu === 1'b1);
  always @(negedge cpu_c)
    if (rst_n === 1'b1) a_r3_cpu_c_fall: assert (clk_cpu === 1'b1);
  always @(negedge pci_clk0)
    if (rst_n === 1'b1) a_r3_pci_fall: assert (clk_pci === 1'b0);
  always @(negedge sdr_clk0)
    if (rst_n === 1'b1) a_r3_sdr_fall: assert (clk_sdr === 1'b0);

  a_r1_cpu_runs: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    (since_rst >= 3'd5 && cpu_want && $past(cpu_want) && $past(cpu_want, 2)
     && $past(cpu_want, 3) && $past(cpu_want, 4)) |-> cpu_t);

  a_r4_pd_cpu: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    (!pd_n && !$past(pd_n) && !$past(pd_n, 2) && !$past(pd_n, 3) && !$past(pd_n, 4))
    |-> (!cpu_t && !cpu_cs));

  a_r4_pd_sdr: assert property (@(negedge clk_sdr) disable iff (!rst_n)
    (!pd_n && !$past(pd_n) && !$past(pd_n, 2) && !$past(pd_n, 3) && !$past(pd_n, 4))
    |-> !sdr_clk0);

  a_r5_cpu_stop: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    (!mode && !cpu_stop_n && !$past(cpu_stop_n) && !$past(cpu_stop_n, 2)
     && !$past(cpu_stop_n, 3) && !$past(cpu_stop_n, 4) && !$past(mode, 4))
    |-> (!cpu_t && !cpu_cs));

  a_r6_cs_phase: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    cpu_cs == cpu_t);

  a_r9_ref0_mode0: assert property (@(negedge clk_ref) disable iff (!rst_n)
    (!mode && !$past(mode) && !$past(mode, 2) && !$past(mode, 3) && !$past(mode, 4))
    |-> !ref_clk0);
endmodule

bind clkgate_bank clkgate_bank_chk u_chk (
  .rst_n(rst_n), .mode(mode), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
  .en_cpu(en_cpu), .clk_cpu(clk_cpu), .clk_pci(clk_pci), .clk_sdr(clk_sdr),
  .clk_ref(clk_ref), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_cs(cpu_cs),
  .pci_clk0(pci_clk[0]), .sdr_clk0(sdr_clk[0]), .ref_clk0(ref_clk[0]));

// File: tb/clkgate_bank_test.sv
`timescale 1ns/1ps
module clkgate_bank_test;
  localparam int NOUT  = 26;
  localparam int I_CPT = 0;
  localparam int I_CPC = 1;
  localparam int I_CS  = 2;
  localparam int I_PCI = 3;
  localparam int I_SDR = 9;
  localparam int I_USB = 22;
  localparam int I_MUX = 23;
  localparam int I_REF = 24;

  logic clk_cpu = 0, clk_pci = 0, clk_sdr = 0, clk_24 = 0, clk_48 = 0, clk_ref = 0;
  always #2  clk_cpu = ~clk_cpu;
  always #6  clk_pci = ~clk_pci;
  always #2  clk_sdr = ~clk_sdr;
  always #8  clk_24  = ~clk_24;
  always #4  clk_48  = ~clk_48;
  always #14 clk_ref = ~clk_ref;

  logic rst_n = 0, mode = 1, pd_n = 1, cpu_stop_n = 1;
  logic en_cpu = 1, en_sdr_last = 1, en_usb = 1, en_mux = 1, sel_mux_hi = 0;
  logic [5:0]  en_pci = '1;
  logic [2:0]  en_sdr_grp = '1;
  logic [1:0]  en_ref = '1;
  logic cpu_t, cpu_c, cpu_cs, usb_clk, mux_clk;
  logic [5:0]  pci_clk;
  logic [12:0] sdr_clk;
  logic [1:0]  ref_clk;
  logic [NOUT-1:0] obs;

  clkgate_bank uut (
    .rst_n(rst_n), .mode(mode), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
    .clk_cpu(clk_cpu), .clk_pci(clk_pci), .clk_sdr(clk_sdr), .clk_24(clk_24),
    .clk_48(clk_48), .clk_ref(clk_ref), .en_cpu(en_cpu), .en_pci(en_pci),
    .en_sdr_grp(en_sdr_grp), .en_sdr_last(en_sdr_last), .en_usb(en_usb),
    .en_mux(en_mux), .sel_mux_hi(sel_mux_hi), .en_ref(en_ref),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_cs(cpu_cs), .pci_clk(pci_clk),
    .sdr_clk(sdr_clk), .usb_clk(usb_clk), .mux_clk(mux_clk), .ref_clk(ref_clk));

  assign obs = {ref_clk, mux_clk, usb_clk, sdr_clk, pci_clk, cpu_cs, cpu_c, cpu_t};

  int n_checks = 0, n_fail = 0, runt_cnt = 0;

  typedef struct {
    int    idx;
    int    rmin;
    int    rmax;
    bit    want_low;
    string req;
  } item_t;
  item_t sb_q[$];
  bit busy = 0;

  function automatic real min_high(int i);
    if (i <= I_CS)      return 1.99;
    else if (i < I_SDR) return 5.99;
    else if (i < I_USB) return 1.99;
    else if (i < I_REF) return 3.99;
    else                return 13.99;
  endfunction

  // R3: continuous high-width monitor on every output
  for (genvar i = 0; i < NOUT; i++) begin : g_width
    realtime t_rise = 0;
    always @(posedge obs[i]) t_rise = $realtime;
    always @(negedge obs[i])
      if (rst_n === 1'b1 && ($realtime - t_rise) < min_high(i)) runt_cnt++;
  end

  task automatic push(int idx, int rmin, int rmax, bit want_low, string req);
    item_t it;
    it.idx = idx; it.rmin = rmin; it.rmax = rmax; it.want_low = want_low; it.req = req;
    sb_q.push_back(it);
  endtask
  task automatic exp_run(int idx, string req);  push(idx, 2, 1000, 0, req); endtask
  task automatic exp_stop(int idx, string req); push(idx, 0, 0, 1, req);    endtask
  task automatic drain();
    while (sb_q.size() != 0 || busy) #1;
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // scoreboard monitor: rising edges and high samples over a 128 ns window
  initial begin
    item_t it;
    int rises, highs;
    logic prev, cur;
    #0.5;
    forever begin
      while (sb_q.size() == 0) #1;
      busy = 1;
      it = sb_q.pop_front();
      rises = 0; highs = 0; prev = obs[it.idx];
      for (int s = 0; s < 128; s++) begin
        #1;
        cur = obs[it.idx];
        if (cur && !prev) rises++;
        if (cur) highs++;
        prev = cur;
      end
      n_checks++;
      if (rises < it.rmin || rises > it.rmax || (it.want_low && highs != 0)) begin
        n_fail++;
        $display("FAIL %s: output %0d actual rises=%0d highs=%0d expected rises %0d..%0d%s",
                 it.req, it.idx, rises, highs, it.rmin, it.rmax,
                 it.want_low ? " held low" : "");
      end
      busy = 0;
    end
  end

  task automatic gap_check(bit new_sel, string req);
    int longest = 0, lowrun = 0;
    sel_mux_hi = new_sel;
    for (int s = 0; s < 300; s++) begin
      #1;
      if (!mux_clk) lowrun++; else lowrun = 0;
      if (lowrun > longest) longest = lowrun;
    end
    check(longest >= 16, req, longest, 16);
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int mism;
    #0.25;
    #50;
    check(obs === '0, "R10 outputs low in reset", int'(obs), 0);
    rst_n = 1;
    #400;
    for (int i = 0; i < NOUT; i++)
      if (i == I_MUX) push(I_MUX, 7, 9, 0, "R7 24MHz selected");
      else exp_run(i, "R1 enabled output runs");
    drain();

    en_cpu = 0; en_pci[2] = 0;
    #400;
    exp_stop(I_CPT, "R6 cpu_t off with one bit");
    exp_stop(I_CPC, "R6 cpu_c off with one bit");
    exp_stop(I_CS,  "R6 cpu_cs off with one bit");
    exp_stop(I_PCI + 2, "R1 pci2 disabled");
    exp_run(I_PCI + 1, "R1 pci1 unaffected");
    exp_run(I_PCI + 3, "R1 pci3 unaffected");
    drain();

    en_cpu = 1; en_pci = '1; en_sdr_grp = 3'b010;
    #400;
    for (int k = 0; k < 12; k++)
      if (k / 4 == 1) exp_run(I_SDR + k, "R2 group1 sdram runs");
      else            exp_stop(I_SDR + k, "R2 other group sdram stopped");
    exp_run(I_SDR + 12, "R2 sdram12 independent of groups");
    drain();
    en_sdr_grp = 3'b111; en_sdr_last = 0;
    #400;
    exp_stop(I_SDR + 12, "R2 sdram12 own bit");
    exp_run(I_SDR + 11, "R2 sdram11 in group2");
    exp_run(I_SDR + 0,  "R2 sdram0 in group0");
    drain();
    en_sdr_last = 1;

    cpu_stop_n = 0;
    #400;
    exp_run(I_CPT, "R5 stop ignored in mode1");
    exp_run(I_REF, "R9 ref0 runs in mode1");
    drain();
    mode = 0;
    #400;
    exp_stop(I_CPT, "R5 cpu_t halted");
    exp_stop(I_CPC, "R5 cpu_c halted");
    exp_stop(I_CS,  "R5 cpu_cs halted");
    exp_run(I_PCI, "R5 pci not halted");
    exp_stop(I_REF, "R9 ref0 low in mode0");
    drain();
    cpu_stop_n = 1;
    #400;
    exp_run(I_CPT, "R5 cpu resumes");
    exp_stop(I_REF, "R9 ref0 still low in mode0");
    drain();
    mode = 1;

    pd_n = 0;
    #400;
    for (int i = 0; i < NOUT; i++) exp_stop(i, "R4 power-down stops all");
    drain();
    pd_n = 1;
    #400;
    exp_run(I_CPT, "R4 cpu resumes after power-down");
    exp_run(I_SDR, "R4 sdram resumes after power-down");
    drain();

    mism = 0;
    for (int s = 0; s < 40; s++) begin
      #1;
      if (cpu_cs !== cpu_t || cpu_c !== ~cpu_t) mism++;
    end
    check(mism == 0, "R6 cs/complement phase", mism, 0);

    gap_check(1'b1, "R8 dead time 24 to 48");
    #100;
    push(I_MUX, 15, 17, 0, "R7 48MHz selected");
    drain();
    gap_check(1'b0, "R8 dead time 48 to 24");
    #100;
    push(I_MUX, 7, 9, 0, "R7 24MHz reselected");
    drain();

    en_usb = 0; en_ref = 2'b01;
    #400;
    exp_stop(I_USB, "R1 usb disabled");
    exp_stop(I_REF + 1, "R1 ref1 disabled");
    exp_run(I_REF, "R1 ref0 still enabled");
    drain();

    check(runt_cnt == 0, "R3 no runt pulses", runt_cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule